// File: doc/BRIEF.md
# Direct-Mapped Cache Line Invalidate-by-Address Unit

This block keeps the tag, valid and dirty state of every line of a direct-mapped data cache and performs one maintenance operation: drop the line that currently holds a given address, without writing it back. The operation arrives as an I-type instruction word together with the value of its base register. The block adds the sign-extended immediate to the base to form the effective address. It splits that address into offset, line index and tag. It then clears the line only when the stored tag matches and the line is valid. A modified line is discarded silently, and its dirty flag is cleared along with the valid flag.

Ordinary cache traffic keeps the state current through a fill port, which writes tag, valid and dirty for one line. A combinational lookup port reports hit and dirty for any address, the way a load/store pipeline would probe the tags. A fault input, raised by the address-translation and protection logic, lets the operation finish without touching the state. A parameter builds the block without a cache, and then every operation finishes as a no-op.

Top module: `dcache_addr_inval`

## Requirements
- R1: The effective address is `op_base` plus the sign-extended 16-bit immediate held in instruction bits 21..6. With the defaults (64 lines of 32 bytes, 32-bit addresses), the line index is address bits 10..5 and the tag is bits 31..11. In general the offset takes log2(line bytes) low bits, the index takes the next log2(lines) bits, and the tag takes the rest.
- R2: An operation is accepted only when `op_valid` is high and instruction bits 5..0 equal 0x13. Any other word with `op_valid` gives no `op_done` and changes no state.
- R3: `op_done` is high for exactly the one cycle after the clock edge that accepted the operation. Operations may be issued on consecutive cycles.
- R4: If the indexed line is valid and its tag equals the address tag, `op_hit` is high together with `op_done`. The line's valid and dirty bits are clear from the next clock edge on.
- R5: If the tag differs or the line is invalid, `op_hit` stays low and the operation changes no valid, dirty or tag state.
- R6: A dirty line that matches is invalidated all the same. No writeback is signalled, and the lookup reports it clean from then on.
- R7: If `op_fault` was high together with the accepted operation, `op_done` still pulses, but `op_hit` stays low and the state is left unchanged.
- R8: With `CACHE_PRESENT` = 0, operations still give `op_done`. `op_hit`, `lk_hit` and `lk_dirty` stay low in every case.
- R9: On a clock edge with `fill_we` high, the line indexed by `fill_addr` takes the tag of `fill_addr` and the values of `fill_valid` and `fill_dirty`.
- R10: If an invalidate that hits and a fill to the same line land on the same clock edge, the invalidate wins. The line ends invalid and clean, and the fill is dropped.
- R11: Synchronous active-high `rst` clears every valid and dirty bit and cancels any operation in flight.
- R12: `lk_hit` is high when the line indexed by `lk_addr` is valid and its tag equals the tag of `lk_addr`. `lk_dirty` is that line's dirty bit. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word presented this cycle |
| op_insn | input | 32 | I-type instruction word |
| op_base | input | AW | Value of the base register |
| op_fault | input | 1 | Data-address fault for this operation; suppresses it |
| fill_we | input | 1 | Fill-port write strobe |
| fill_addr | input | AW | Address whose line and tag are written |
| fill_valid | input | 1 | Valid value written by the fill |
| fill_dirty | input | 1 | Dirty value written by the fill |
| lk_addr | input | AW | Lookup address |
| lk_hit | output | 1 | Lookup address is cached |
| lk_dirty | output | 1 | Dirty bit of the line indexed by the lookup |
| op_done | output | 1 | Operation finished this cycle |
| op_hit | output | 1 | Operation invalidated a line |

## Verification
The hardest case to reach is the collision of the invalidate's write stage with a fill to the same line on the same edge. The fill must arrive exactly one cycle after the instruction is issued, and the line must still match at that time. The directed stimulus first fills a line, issues the invalidate, and then drives a fill with a different tag to that index on the following cycle. The lookup then shows that neither the new tag nor its dirty bit survived. A random phase packs tags and indices into a small space and mixes faults, wrong opcodes, negative offsets and back-to-back operations. This produces many more such coincidences, and every cycle is compared against the behavioural model.

// File: rtl/dcinv_pkg.sv
package dcinv_pkg;
   // operation code carried in the low six bits of the instruction word
   localparam logic [5:0] OPC_INVAL_ADDR = 6'h13;
   localparam int         OPC_LSB        = 0;
   localparam int         OPC_W          = 6;
   // immediate field position
   localparam int         IMM_LSB        = 6;
   localparam int         IMM_W          = 16;
   localparam int         INSN_W         = 32;
endpackage

// File: rtl/dcinv_decode.sv
module dcinv_decode
   import dcinv_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [AW-1:0]     base,
   output logic              is_inval,
   output logic [AW-1:0]     eff_addr
);
   generate
      if (AW < IMM_W) begin : g_bad_aw
         $error("dcinv_decode: AW must be at least the immediate width");
      end
   endgenerate

   logic [IMM_W-1:0] imm;
   logic [AW-1:0]    imm_ext;
   logic             unused_insn_hi;

   assign imm            = insn[IMM_LSB +: IMM_W];
   assign imm_ext        = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
   assign eff_addr       = base + imm_ext;
   assign is_inval       = (insn[OPC_LSB +: OPC_W] == OPC_INVAL_ADDR);
   assign unused_insn_hi = ^insn[INSN_W-1:IMM_LSB+IMM_W];
endmodule

// File: rtl/dcinv_tag_store.sv
module dcinv_tag_store #(
   parameter int LINES = 64,
   parameter int TAG_W = 21,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst,
   // read port for the invalidate stage
   input  logic [IDX_W-1:0] a_idx,
   output logic [TAG_W-1:0] a_tag,
   output logic             a_vld,
   // read port for lookups
   input  logic [IDX_W-1:0] b_idx,
   output logic [TAG_W-1:0] b_tag,
   output logic             b_vld,
   output logic             b_dirty,
   // fill write
   input  logic             fill_we,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             fill_v,
   input  logic             fill_d,
   // invalidate write; has priority over fill
   input  logic             clr_we,
   input  logic [IDX_W-1:0] clr_idx
);
   generate
      if ((1 << IDX_W) != LINES) begin : g_bad_lines
         $error("dcinv_tag_store: LINES must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("dcinv_tag_store: tag width must be positive");
      end
   endgenerate

   logic [LINES-1:0][TAG_W-1:0] tag_q;
   logic [LINES-1:0]            vld_q;
   logic [LINES-1:0]            dty_q;

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         logic clr_sel;
         logic fill_sel;
         assign clr_sel  = clr_we  && (clr_idx  == IDX_W'(i));
         assign fill_sel = fill_we && (fill_idx == IDX_W'(i));

         always_ff @(posedge clk) begin
            if (rst) begin
               vld_q[i] <= 1'b0;
               dty_q[i] <= 1'b0;
            end else if (clr_sel) begin
               vld_q[i] <= 1'b0;
               dty_q[i] <= 1'b0;
            end else if (fill_sel) begin
               vld_q[i] <= fill_v;
               dty_q[i] <= fill_d;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst && fill_sel && !clr_sel) begin
               tag_q[i] <= fill_tag;
            end
         end
      end
   endgenerate

   assign a_tag   = tag_q[a_idx];
   assign a_vld   = vld_q[a_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_vld   = vld_q[b_idx];
   assign b_dirty = dty_q[b_idx];

   // a cleared line reads invalid and clean afterwards
   assert_line_cleared_R4: assert property (@(posedge clk) disable iff (rst)
      clr_we |=> (!vld_q[$past(clr_idx)] && !dty_q[$past(clr_idx)]));

   // clear beats a same-index fill
   assert_clear_beats_fill_R10: assert property (@(posedge clk) disable iff (rst)
      (clr_we && fill_we && (clr_idx == fill_idx)) |=> !vld_q[$past(clr_idx)]);

   // without any write the state holds
   assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (!clr_we && !fill_we) |=> ($stable(vld_q) && $stable(dty_q)));

   // reset empties the store
   assert_reset_clears_R11: assert property (@(posedge clk)
      rst |=> ((vld_q == '0) && (dty_q == '0)));
endmodule

// File: rtl/dcache_addr_inval.sv
module dcache_addr_inval
   import dcinv_pkg::*;
#(
   parameter int LINES         = 64,
   parameter int LINE_BYTES    = 32,
   parameter int AW            = 32,
   parameter bit CACHE_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [INSN_W-1:0] op_insn,
   input  logic [AW-1:0]     op_base,
   input  logic              op_fault,
   input  logic              fill_we,
   input  logic [AW-1:0]     fill_addr,
   input  logic              fill_valid,
   input  logic              fill_dirty,
   input  logic [AW-1:0]     lk_addr,
   output logic              lk_hit,
   output logic              lk_dirty,
   output logic              op_done,
   output logic              op_hit
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = AW - OFF_W - IDX_W;
   localparam int TAG_LSB = OFF_W + IDX_W;

   generate
      if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line_bytes
         $error("dcache_addr_inval: LINE_BYTES must be a power of two");
      end
      if ((1 << IDX_W) != LINES) begin : g_bad_lines
         $error("dcache_addr_inval: LINES must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_split
         $error("dcache_addr_inval: address too narrow for offset and index");
      end
   endgenerate

   // ---- stage one: decode and register the effective address ----
   logic          dec_is_inval;
   logic [AW-1:0] dec_ea;

   dcinv_decode #(.AW(AW)) decode_i (
      .insn     (op_insn),
      .base     (op_base),
      .is_inval (dec_is_inval),
      .eff_addr (dec_ea)
   );

   logic          s_vld;
   logic          s_flt;
   logic [AW-1:0] s_ea;

   always_ff @(posedge clk) begin
      if (rst) s_vld <= 1'b0;
      else     s_vld <= op_valid && dec_is_inval;
   end

   always_ff @(posedge clk) begin
      s_ea  <= dec_ea;
      s_flt <= op_fault;
   end

   assign op_done = s_vld;

   // ---- stage two: compare and clear ----
   generate
      if (CACHE_PRESENT) begin : g_cache
         logic [IDX_W-1:0] s_idx, lk_idx, fill_idx;
         logic [TAG_W-1:0] s_tag, lk_tag, fill_tag;
         logic [TAG_W-1:0] a_tag, b_tag;
         logic             a_vld, b_vld, b_dirty;
         logic             clr_we;
         logic             unused_offsets;

         assign s_idx    = s_ea[OFF_W +: IDX_W];
         assign s_tag    = s_ea[TAG_LSB +: TAG_W];
         assign lk_idx   = lk_addr[OFF_W +: IDX_W];
         assign lk_tag   = lk_addr[TAG_LSB +: TAG_W];
         assign fill_idx = fill_addr[OFF_W +: IDX_W];
         assign fill_tag = fill_addr[TAG_LSB +: TAG_W];
         assign unused_offsets = ^{s_ea[OFF_W-1:0], lk_addr[OFF_W-1:0],
                                   fill_addr[OFF_W-1:0]};

         dcinv_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) store_i (
            .clk      (clk),
            .rst      (rst),
            .a_idx    (s_idx),
            .a_tag    (a_tag),
            .a_vld    (a_vld),
            .b_idx    (lk_idx),
            .b_tag    (b_tag),
            .b_vld    (b_vld),
            .b_dirty  (b_dirty),
            .fill_we  (fill_we),
            .fill_idx (fill_idx),
            .fill_tag (fill_tag),
            .fill_v   (fill_valid),
            .fill_d   (fill_dirty),
            .clr_we   (clr_we),
            .clr_idx  (s_idx)
         );

         // dirty state is deliberately not consulted
         assign clr_we   = s_vld && !s_flt && a_vld && (a_tag == s_tag);
         assign op_hit   = clr_we;
         assign lk_hit   = b_vld && (b_tag == lk_tag);
         assign lk_dirty = b_dirty;
      end else begin : g_no_cache
         logic unused_no_cache;
         assign unused_no_cache = ^{s_ea, s_flt, fill_we, fill_addr,
                                    fill_valid, fill_dirty, lk_addr};
         assign op_hit   = 1'b0;
         assign lk_hit   = 1'b0;
         assign lk_dirty = 1'b0;
      end
   endgenerate

   // ---- checks ----
   assert_done_follows_R3: assert property (@(posedge clk) disable iff (rst)
      (op_valid && (op_insn[OPC_LSB +: OPC_W] == OPC_INVAL_ADDR)) |=> op_done);

   assert_bad_opcode_R2: assert property (@(posedge clk) disable iff (rst)
      (op_valid && (op_insn[OPC_LSB +: OPC_W] != OPC_INVAL_ADDR)) |=> !op_done);

   assert_hit_needs_done_R4: assert property (@(posedge clk) disable iff (rst)
      op_hit |-> op_done);

   assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_fault) |=> !op_hit);

   assert_idle_no_done_R3: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> !op_done);
endmodule

// File: tb/dcache_addr_inval_tb_top.sv
`timescale 1ns/1ps
module dcache_addr_inval_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        op_valid, op_fault;
   logic [31:0] op_insn, op_base;
   logic        fill_we, fill_valid, fill_dirty;
   logic [31:0] fill_addr, lk_addr;
   logic        lk_hit, lk_dirty, op_done, op_hit;
   logic        na_lk_hit, na_lk_dirty, na_done, na_hit;

   always #2 clk = ~clk;   // 250 MHz

   dcache_addr_inval dut_i (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_insn(op_insn),
      .op_base(op_base), .op_fault(op_fault), .fill_we(fill_we),
      .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_dirty(fill_dirty),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_dirty(lk_dirty),
      .op_done(op_done), .op_hit(op_hit));

   dcache_addr_inval #(.CACHE_PRESENT(1'b0)) dut_absent_i (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_insn(op_insn),
      .op_base(op_base), .op_fault(op_fault), .fill_we(fill_we),
      .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_dirty(fill_dirty),
      .lk_addr(lk_addr), .lk_hit(na_lk_hit), .lk_dirty(na_lk_dirty),
      .op_done(na_done), .op_hit(na_hit));

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit chk_en = 1'b0;
   string cur_req = "R4";
   logic last_hit;

   // behavioural reference state
   int unsigned m_tag [64];
   bit          m_v   [64];
   bit          m_d   [64];
   bit          m_pend, m_flt;
   logic [31:0] m_ea;

   function automatic int idx_of(logic [31:0] a); return int'(a[10:5]); endfunction
   function automatic int unsigned tag_of(logic [31:0] a); return 32'(a[31:11]); endfunction

   function automatic bit model_hit();
      return m_pend && !m_flt && m_v[idx_of(m_ea)] && (m_tag[idx_of(m_ea)] == tag_of(m_ea));
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_d[i] = 0; end
         m_pend = 0;
      end else begin
         bit h;
         h = model_hit();
         if (fill_we && !(h && idx_of(fill_addr) == idx_of(m_ea))) begin
            m_tag[idx_of(fill_addr)] = tag_of(fill_addr);
            m_v[idx_of(fill_addr)]   = fill_valid;
            m_d[idx_of(fill_addr)]   = fill_dirty;
         end
         if (h) begin m_v[idx_of(m_ea)] = 0; m_d[idx_of(m_ea)] = 0; end
         m_pend = op_valid && (op_insn[5:0] == 6'h13);
         m_ea   = op_base + {{16{op_insn[21]}}, op_insn[21:6]};
         m_flt  = op_fault;
      end
   end

   // compare against the model every cycle, away from the active edge
   always @(negedge clk) begin
      if (chk_en) begin
         bit eh, elh;
         eh  = model_hit();
         elh = m_v[idx_of(lk_addr)] && (m_tag[idx_of(lk_addr)] == tag_of(lk_addr));
         check(op_done == m_pend, "R3", "op_done", op_done, m_pend);
         check(op_hit == eh, cur_req, "op_hit", op_hit, eh);
         check(lk_hit == elh, "R12", "lk_hit", lk_hit, elh);
         check(lk_dirty == m_d[idx_of(lk_addr)], "R12", "lk_dirty", lk_dirty, m_d[idx_of(lk_addr)]);
         check(na_done == m_pend, "R8", "absent op_done", na_done, m_pend);
         check(!na_hit && !na_lk_hit && !na_lk_dirty, "R8", "absent outputs",
               {na_hit, na_lk_hit, na_lk_dirty}, 0);
         if (op_done) last_hit = op_hit;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step(); @(posedge clk); #1; endtask

   function automatic logic [31:0] mk_insn(logic [15:0] imm, logic [5:0] opc);
      return {5'd6, 5'd0, imm, opc};
   endfunction

   task automatic fill(logic [31:0] a, bit v, bit d);
      fill_we = 1; fill_addr = a; fill_valid = v; fill_dirty = d;
      step();
      fill_we = 0;
   endtask

   // issue one operation and wait until its write edge has passed
   task automatic issue(logic [31:0] base, int imm, bit flt, logic [5:0] opc);
      op_valid = 1; op_base = base; op_insn = mk_insn(16'(imm), opc); op_fault = flt;
      step();
      op_valid = 0; op_fault = 0;
      step();
   endtask

   task automatic probe(logic [31:0] a, bit eh, bit ed, string req);
      lk_addr = a;
      @(negedge clk);
      check(lk_hit == eh, req, "probe hit", lk_hit, eh);
      check(lk_dirty == ed, req, "probe dirty", lk_dirty, ed);
      step();
   endtask

   initial begin
      rst = 1; op_valid = 0; op_fault = 0; op_insn = 0; op_base = 0;
      fill_we = 0; fill_addr = 0; fill_valid = 0; fill_dirty = 0; lk_addr = 0;
      last_hit = 0;
      repeat (3) step();
      rst = 0;
      chk_en = 1;

      // R11: reset state empty, and reset wipes filled lines
      probe(32'h0, 0, 0, "R11");
      fill(32'h0000_0040, 1, 1);
      probe(32'h0000_0040, 1, 1, "R9");
      rst = 1; step(); rst = 0;
      probe(32'h0000_0040, 0, 0, "R11");

      // R4: plain matching invalidate
      cur_req = "R4";
      fill(32'h0000_2040, 1, 0);
      issue(32'h0000_2000, 16'h40, 0, 6'h13);
      check(last_hit == 1, "R4", "hit on match", last_hit, 1);
      probe(32'h0000_2040, 0, 0, "R4");

      // R1 + R6: negative offset reaches a dirty line, no writeback
      cur_req = "R6";
      fill(32'h0000_4F80, 1, 1);
      issue(32'h0000_5000, -100, 0, 6'h13);   // EA 0x4F9C
      check(last_hit == 1, "R1", "negative offset hit", last_hit, 1);
      probe(32'h0000_4F80, 0, 0, "R6");

      // R5: same index, other tag; then invalid line with equal tag
      cur_req = "R5";
      fill(32'h0000_8060, 1, 1);
      issue(32'h0001_8060, 0, 0, 6'h13);
      check(last_hit == 0, "R5", "miss on tag mismatch", last_hit, 0);
      probe(32'h0000_8060, 1, 1, "R5");
      fill(32'h0000_9080, 0, 0);
      issue(32'h0000_9080, 0, 0, 6'h13);
      check(last_hit == 0, "R5", "miss on invalid line", last_hit, 0);

      // R7: fault suppresses
      cur_req = "R7";
      fill(32'h0000_A0A0, 1, 0);
      issue(32'h0000_A0A0, 0, 1, 6'h13);
      check(last_hit == 0, "R7", "fault hit", last_hit, 0);
      probe(32'h0000_A0A0, 1, 0, "R7");

      // R2: wrong opcode ignored
      cur_req = "R2";
      last_hit = 0;
      issue(32'h0000_A0A0, 0, 0, 6'h12);
      probe(32'h0000_A0A0, 1, 0, "R2");

      // R10: fill collides with the invalidate write stage
      cur_req = "R10";
      fill(32'h0000_C0C0, 1, 0);
      op_valid = 1; op_base = 32'h0000_C0C0; op_insn = mk_insn(16'h0, 6'h13);
      step();
      op_valid = 0;
      fill_we = 1; fill_addr = 32'h0000_E0C0; fill_valid = 1; fill_dirty = 1;
      step();
      fill_we = 0;
      probe(32'h0000_E0C0, 0, 0, "R10");
      probe(32'h0000_C0C0, 0, 0, "R10");

      // random mix: faults, bad opcodes, negative offsets, back-to-back
      cur_req = "R4";
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a;
         int imm;
         a = {19'($urandom_range(0, 3)), 2'b0, 6'($urandom_range(0, 7)), 5'($urandom)};
         imm = $urandom_range(0, 400) - 200;
         op_valid  = ($urandom_range(0, 2) != 0);
         op_base   = a - 32'(imm);
         op_insn   = mk_insn(16'(imm), ($urandom_range(0, 9) == 0) ? 6'h03 : 6'h13);
         op_fault  = ($urandom_range(0, 7) == 0);
         fill_we   = ($urandom_range(0, 1) == 0);
         fill_addr = {19'($urandom_range(0, 3)), 2'b0, 6'($urandom_range(0, 7)), 5'd0};
         fill_valid = ($urandom_range(0, 3) != 0);
         fill_dirty = $urandom_range(0, 1);
         lk_addr   = {19'($urandom_range(0, 3)), 2'b0, 6'($urandom_range(0, 7)), 5'd0};
         step();
      end
      op_valid = 0; fill_we = 0; op_fault = 0;
      repeat (3) step();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule